// File: doc/BRIEF.md
# GPIO Pin Interrupt Channel Router

This block takes a wide bank of GPIO pin levels and turns any chosen pin into one of 32 interrupt channels. Each channel is programmed with a source pin index, an enable bit and a two-bit sense mode. The channel keeps a status flag and drives an active-high request line towards the interrupt controller. Pins are synchronised into the core clock before they are used. Edge flags stay set until software clears them. Level flags follow the selected pin.

Software reaches the block through a word-addressed write/read port. Select words 0..7 pack four channels each, with an enable bit at the top of every byte. Sense words 8..9 pack sixteen two-bit modes each. Word 10 reads back status, and word 11 is a write-one-to-clear port.

Reprogramming a channel's source or enable can make the observed level jump, and that jump looks like an edge. A clear written in the very next cycle removes the spurious flag, so software can reprogram a channel and then clear it.

Top module: `irq_router`

## Requirements
- R1: After reset, status_o, irq_o and every readable word (0..10) are zero.
- R2: Channel n is configured in word n/4, byte n%4. Bits [6:0] of the byte give the source pin index and bit 7 enables the channel. Written words read back unchanged.
- R3: The sense mode of channel n is held in word 8+n/16, bits [2(n%16)+1:2(n%16)], with 0 = rising edge, 1 = falling edge, 2 = level high and 3 = level low. These words read back unchanged.
- R4: In an edge mode, the matching transition of the selected pin sets the channel flag within three clock edges, and the opposite transition leaves the flag unchanged.
- R5: In a level mode, an enabled channel with a valid source has a flag that tracks the synchronised pin: it is 1 while the pin is at the active level and 0 otherwise.
- R6: A source index above NUM_PINS-1 (85) selects nothing. No flag is raised in any mode, including level low.
- R7: A disabled channel never sets its flag. irq_o[n] equals status_o[n] gated by the enable bit, so a flag that was set before the channel was disabled stays visible in status but not on the request line.
- R8: Writing word 11 with bit n set clears flag n when the channel is in an edge mode. A zero bit leaves its flag alone. In a level mode the write has no effect.
- R9: A clear for an edge-mode channel that lands in the same cycle as a newly detected edge wins. A clear written in the cycle right after a select change therefore removes the glitch flag that the change produced.
- R10: Word 10 returns the 32 status flags. Writes to word 10 change neither the flags nor the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 86 | Asynchronous GPIO pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| status_o | output | 32 | Per-channel status flags |
| irq_o | output | 32 | Per-channel interrupt requests |

## Verification
On every cycle, the assertions check four things:
- a disabled channel or a channel with an out-of-range source cannot raise its flag;
- an edge-mode clear always leaves the flag low on the next edge;
- a level-high flag follows the selected pin one cycle later;
- a write to the status word disturbs no configuration.

Only the bench scenarios show the rest:
- the field packing at the ports;
- the three-edge latency from pin to flag;
- the difference between rising and falling modes;
- that clears are ignored in level modes;
- that a select change produces a glitch flag, and that a clear written straight after it removes that flag.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned SRC_W   = 7;
  localparam int unsigned SNS_W   = 2;

  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;
endpackage

// File: rtl/irq_router_sync.sv
module irq_router_sync #(
  parameter int unsigned WIDTH  = 86,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [WORD_W-1:0]             rdata_o,
  input  logic [NUM_CH-1:0]             status_i,
  output logic [NUM_CH-1:0][SRC_W-1:0]  src_o,
  output logic [NUM_CH-1:0]             en_o,
  output sense_e [NUM_CH-1:0]           sns_o,
  output logic [NUM_CH-1:0]             clr_o
);
  localparam int unsigned SEL_PER   = WORD_W / FIELD_W;
  localparam int unsigned SNS_PER   = WORD_W / SNS_W;
  localparam int unsigned SEL_WORDS = NUM_CH / SEL_PER;
  localparam int unsigned SNS_WORDS = NUM_CH / SNS_PER;
  localparam int unsigned SNS_BASE  = SEL_WORDS;
  localparam int unsigned STAT_ADDR = SNS_BASE + SNS_WORDS;
  localparam int unsigned CLR_ADDR  = STAT_ADDR + 1;

  logic [SEL_WORDS-1:0][WORD_W-1:0] sel_q;
  logic [SNS_WORDS-1:0][WORD_W-1:0] sns_q;

  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[w] <= '0;
      else if (we_i && addr_i == ADDR_W'(w)) sel_q[w] <= wdata_i;
    end
  end

  for (genvar w = 0; w < SNS_WORDS; w++) begin : g_sns
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sns_q[w] <= '0;
      else if (we_i && addr_i == ADDR_W'(SNS_BASE + w)) sns_q[w] <= wdata_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_field
    assign src_o[c] = sel_q[c/SEL_PER][(c%SEL_PER)*FIELD_W +: SRC_W];
    assign en_o[c]  = sel_q[c/SEL_PER][(c%SEL_PER)*FIELD_W + FIELD_W - 1];
    assign sns_o[c] = sense_e'(sns_q[c/SNS_PER][(c%SNS_PER)*SNS_W +: SNS_W]);
  end

  assign clr_o = (we_i && addr_i == ADDR_W'(CLR_ADDR)) ? wdata_i[NUM_CH-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < SEL_WORDS; w++)
      if (addr_i == ADDR_W'(w)) rdata_o = sel_q[w];
    for (int w = 0; w < SNS_WORDS; w++)
      if (addr_i == ADDR_W'(SNS_BASE + w)) rdata_o = sns_q[w];
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = WORD_W'(status_i);
  end

  // R10: status word is read-only
  p_status_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(STAT_ADDR)) |=> ($stable(sel_q) && $stable(sns_q)));
endmodule

// File: rtl/irq_router_chan.sv
module irq_router_chan
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 86
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SRC_W-1:0]    src_i,
  input  logic                en_i,
  input  sense_e              sns_i,
  input  logic                clr_i,
  output logic                flag_o,
  output logic                req_o
);
  localparam int unsigned PAD_W = 1 << SRC_W;
  localparam logic [SRC_W:0] SRC_LIM = (SRC_W+1)'(NUM_PINS);

  logic [PAD_W-1:0] pad;
  logic valid, pin_lvl, cur, lvl_q, flag_q, flag_d, rise, fall, edge_mode;

  assign pad     = PAD_W'(pins_i);
  assign valid   = {1'b0, src_i} < SRC_LIM;
  assign pin_lvl = valid & pad[src_i];
  // observed level; a source or enable change can move it (glitch edge)
  assign cur     = en_i & pin_lvl;
  assign rise    = cur & ~lvl_q;
  assign fall    = ~cur & lvl_q;
  assign edge_mode = (sns_i == SNS_RISE) || (sns_i == SNS_FALL);

  always_comb begin
    unique case (sns_i)
      SNS_RISE: flag_d = clr_i ? 1'b0 : (flag_q | (en_i & rise));
      SNS_FALL: flag_d = clr_i ? 1'b0 : (flag_q | (en_i & fall));
      SNS_HIGH: flag_d = en_i & valid & pin_lvl;
      default:  flag_d = en_i & valid & ~pad[src_i];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= cur;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = flag_q & en_i;

  p_disabled_no_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);

  p_bad_src_no_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid && $past(!valid) && !flag_q) |=> !flag_q);

  // R9: clear also beats a same-cycle edge
  p_edge_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && edge_mode) |=> !flag_q);

  p_level_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid && sns_i == SNS_HIGH) |=> (flag_q == $past(pin_lvl)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 86,
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic [NUM_CH-1:0]   status_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PINS-1:0]            pins_s;
  logic [NUM_CH-1:0][SRC_W-1:0]   ch_src;
  logic [NUM_CH-1:0]              ch_en;
  sense_e [NUM_CH-1:0]            ch_sns;
  logic [NUM_CH-1:0]              ch_clr;

  irq_router_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_s)
  );

  irq_router_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .status_i (status_o),
    .src_o    (ch_src),
    .en_o     (ch_en),
    .sns_o    (ch_sns),
    .clr_o    (ch_clr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irq_router_chan #(.NUM_PINS(NUM_PINS)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pins_i (pins_s),
      .src_i  (ch_src[c]),
      .en_i   (ch_en[c]),
      .sns_i  (ch_sns[c]),
      .clr_i  (ch_clr[c]),
      .flag_o (status_o[c]),
      .req_o  (irq_o[c])
    );
  end
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [85:0] pins = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    rd(0, v); chk("R1 word0", v, 0);
    rd(8, v); chk("R1 word8", v, 0);
    rd(10, v); chk("R1 word10", v, 0);
  endtask

  task automatic t_pack();
    logic [31:0] v;
    wr(1, 32'h0094_0000);
    rd(1, v); chk("R2 readback word1", v, 32'h0094_0000);
    rd(0, v); chk("R2 word0 untouched", v, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    pins[20] = 1'b1; cyc(4);
    chk("R4 rise sets ch6", status, 32'h40);
    chk("R2 irq ch6", irq, 32'h40);
    wr(11, 32'h40); cyc(2);
    chk("R8 clear ch6", status, 0);
    pins[20] = 1'b0; cyc(4);
    chk("R4 fall ignored in rise mode", status, 0);
    wr(8, 32'h0000_1000);
    rd(8, v); chk("R3 readback word8", v, 32'h0000_1000);
    cyc(2);
    pins[20] = 1'b1; cyc(4);
    chk("R4 rise ignored in fall mode", status, 0);
    pins[20] = 1'b0; cyc(4);
    chk("R3 R4 fall sets ch6", status, 32'h40);
    wr(11, 32'h40); cyc(2);
  endtask

  task automatic t_level();
    wr(9, 32'h8);
    wr(4, 32'h0000_D500); cyc(4);
    chk("R5 level high pin low", status, 0);
    pins[85] = 1'b1; cyc(4);
    chk("R5 level high pin high", status, 32'h0002_0000);
    chk("R5 irq ch17", irq, 32'h0002_0000);
    wr(11, 32'h0002_0000); cyc(2);
    chk("R8 clear ignored in level", status, 32'h0002_0000);
    pins[85] = 1'b0; cyc(4);
    chk("R5 level follows pin", status, 0);
    wr(9, 32'hC); cyc(4);
    chk("R5 level low asserts", status, 32'h0002_0000);
  endtask

  task automatic t_invalid();
    wr(4, 32'h0000_D600); cyc(4);
    chk("R6 src 0x56 level low", status, 0);
    chk("R6 irq", irq, 0);
    wr(4, 32'h0000_FF00); cyc(4);
    chk("R6 src 0x7f level low", status, 0);
    wr(9, 32'h8);
    pins[85] = 1'b1; cyc(4);
    chk("R6 src 0x7f level high", status, 0);
    pins[85] = 1'b0;
    wr(4, 0); wr(9, 0); cyc(4);
  endtask

  task automatic t_disable();
    wr(8, 0);
    wr(1, 32'h0014_0000);
    pins[20] = 1'b1; cyc(4);
    chk("R7 disabled no flag", status, 0);
    chk("R7 disabled no irq", irq, 0);
    pins[20] = 1'b0; cyc(4);
    wr(1, 32'h0094_0000); cyc(2);
    pins[20] = 1'b1; cyc(4);
    chk("R7 enabled flag", status, 32'h40);
    wr(1, 32'h0014_0000); cyc(2);
    chk("R7 flag kept after disable", status, 32'h40);
    chk("R7 irq gated", irq, 0);
  endtask

  task automatic t_glitch();
    pins[3] = 1'b0; pins[9] = 1'b1; cyc(4);
    wr(0, 32'h83); cyc(4);
    chk("R9 ch0 quiet", status, 32'h40);
    wr(0, 32'h89);
    wr(11, 32'h1); cyc(4);
    chk("R9 glitch removed", status, 32'h40);
    wr(0, 32'h83); cyc(4);
    chk("R4 fall glitch ignored", status, 32'h40);
    wr(0, 32'h89); cyc(4);
    chk("R9 glitch without clear", status, 32'h41);
    chk("R7 irq only enabled", irq, 32'h1);
  endtask

  task automatic t_status();
    logic [31:0] v;
    rd(10, v); chk("R10 status word", v, 32'h41);
    @(negedge clk);
    wr(10, 0); cyc(2);
    rd(10, v); chk("R10 write zero ignored", v, 32'h41);
    @(negedge clk);
    wr(10, 32'hFFFF_FFFF); cyc(2);
    chk("R10 write ones ignored", status, 32'h41);
    rd(0, v); chk("R10 config kept", v, 32'h89);
    @(negedge clk);
    wr(11, 32'h1); cyc(2);
    chk("R8 selective clear", status, 32'h40);
    wr(11, 32'h40); cyc(2);
    chk("R8 final clear", status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_edge();
    t_level();
    t_invalid();
    t_disable();
    t_glitch();
    t_status();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule